// File: doc/BRIEF.md
# Immediate-Operand Instruction Stream Engine

This block is a small sequential execution engine. It pulls an instruction stream in one byte per cycle from a byte-wide fetch port, decodes instructions that carry a 32-bit immediate, and executes them against eight 32-bit general registers, three compare flags and an external word data port. Accumulator forms operate on register 0. A group form and a move form take an extra addressing byte, which selects either a register directly or the memory word whose address a register holds. Register-targeted moves take their destination from the opcode itself. A push form stores the immediate below the stack pointer.

Each instruction ends with a one-cycle completion pulse. An opcode or addressing byte outside the supported set raises a sticky error and freezes the engine until reset. A read-only register view port lets the surrounding logic observe any register.

Top module: `immop_engine`

## Requirements
- R1: While reset is low (asynchronous, active low), fetch_addr, done, err and all three flags are 0, and every register read through view_sel/view_data is 0.
- R2: An immediate is four stream bytes with the least significant byte first, so bytes 0a 0b 0c 0d give 0x0d0c0b0a. Opcodes 0xb8 through 0xbf write the immediate to the register numbered by opcode bits [2:0].
- R3: Opcodes 0x2d, 0x25, 0x0d and 0x35 replace register 0 with register 0 minus, AND, OR and XOR the immediate. No addressing byte follows these opcodes.
- R4: Opcode 0x3d compares register 0 with the immediate and leaves register 0 unchanged. For d = reg0 - imm: flag_sf = d[31], flag_zf = (d == 0), and flag_of = 1 exactly when the operand signs differ and the sign of d differs from the sign of reg0.
- R5: Opcode 0x81 reads an addressing byte and then an immediate. Addressing-byte bits [5:3] pick the operation: 0 add, 1 or, 4 and, 5 subtract, 6 xor, 7 compare. Bits [7:6] = 11 select register bits [2:0] as the operand, and the result is written back to it. Compare updates only the flags, as in R4.
- R6: When addressing-byte bits [7:6] = 00, the operand is the memory word at the address held in register bits [2:0]. The result is written back to that word, except for compare, which writes nothing.
- R7: Opcode 0xc7 writes the immediate to the register or memory word chosen by its addressing byte, as in R5/R6. Addressing-byte bits [5:3] have no effect.
- R8: Opcode 0x68 lowers register 4 by 4 and stores the immediate at the new register-4 address (0x14 becomes 0x10).
- R9: The flags change only on compare operations. Arithmetic, logic, move and push leave them as they were.
- R10: An unsupported opcode, a 0x81 operation code of 2 or 3, or an addressing mode of 01 or 10 sets err. From then on fetch_addr holds on the offending byte, and no further done or memory write occurs.
- R11: fetch_addr starts at 0 and advances by one for every byte consumed, so eight 5-byte instructions leave it at 40.
- R12: done is high for exactly one cycle per instruction. Consecutive pulses are 6 cycles apart when the later instruction is 5 bytes long, and 7 cycles apart when it is 6 bytes long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | output | 16 | Address of the stream byte wanted this cycle |
| fetch_byte | input | 8 | Stream byte at fetch_addr, valid in the same cycle |
| mem_addr | output | 32 | Byte address of the data word |
| mem_rdata | input | 32 | Data word at mem_addr, valid in the same cycle |
| mem_we | output | 1 | Write mem_wdata to mem_addr at the clock edge |
| mem_wdata | output | 32 | Data to write |
| view_sel | input | 3 | Register number to observe |
| view_data | output | 32 | Content of the selected register |
| flag_sf | output | 1 | Sign flag from the last compare |
| flag_zf | output | 1 | Zero flag from the last compare |
| flag_of | output | 1 | Overflow flag from the last compare |
| done | output | 1 | One-cycle pulse after each instruction completes |
| err | output | 1 | Sticky error; the engine is halted |

## Verification
An instruction of B bytes uses B fetch cycles and one execute cycle. Its register, flag and memory results land at the same edge that raises done, B+1 cycles after its opcode is presented. The bench therefore waits for done at the falling edge, compares the spacing of pulses with 6 or 7 cycles, and reads registers, flags and the data model only in that window, before the next execute edge. Errors are registered one edge after the bad byte appears, so the bench checks err and the frozen fetch_addr after a margin of several cycles.

// File: rtl/immop_pkg.sv
package immop_pkg;
   localparam int REG_COUNT = 8;
   localparam int REG_IDX_W = 3;

   typedef enum logic [2:0] {
      ST_OPCODE = 3'd0,
      ST_MODE   = 3'd1,
      ST_IMM    = 3'd2,
      ST_EXEC   = 3'd3,
      ST_HALT   = 3'd4
   } state_t;

   typedef enum logic [2:0] {
      FN_ADD, FN_OR, FN_AND, FN_SUB, FN_XOR, FN_CMP, FN_PASS
   } alu_fn_t;

   typedef enum logic [1:0] {
      DST_ACC, DST_RM, DST_OPREG, DST_PUSH
   } dst_t;

   localparam logic [1:0] MODE_DIRECT   = 2'b11;
   localparam logic [1:0] MODE_INDIRECT = 2'b00;
endpackage

// File: rtl/immop_decode.sv
module immop_decode
   import immop_pkg::*;
(
   input  logic [7:0] opcode,
   input  logic [7:3] mode_hi,
   output logic       op_ok,
   output logic       needs_mode,
   output logic       mode_ok,
   output alu_fn_t    fn,
   output dst_t       dst
);
   logic    grp;
   logic    sub_ok;
   alu_fn_t sub_fn;

   // operation code carried in the addressing byte of the group form
   always_comb begin
      sub_ok = 1'b1;
      case (mode_hi[5:3])
         3'd0:    sub_fn = FN_ADD;
         3'd1:    sub_fn = FN_OR;
         3'd4:    sub_fn = FN_AND;
         3'd5:    sub_fn = FN_SUB;
         3'd6:    sub_fn = FN_XOR;
         3'd7:    sub_fn = FN_CMP;
         default: begin
            sub_fn = FN_PASS;
            sub_ok = 1'b0;
         end
      endcase
   end

   always_comb begin
      op_ok      = 1'b1;
      needs_mode = 1'b0;
      grp        = 1'b0;
      fn         = FN_PASS;
      dst        = DST_ACC;
      casez (opcode)
         8'h2d:        fn = FN_SUB;
         8'h25:        fn = FN_AND;
         8'h0d:        fn = FN_OR;
         8'h35:        fn = FN_XOR;
         8'h3d:        fn = FN_CMP;
         8'b1011_1???: dst = DST_OPREG;
         8'hc7: begin
            needs_mode = 1'b1;
            dst        = DST_RM;
         end
         8'h81: begin
            needs_mode = 1'b1;
            dst        = DST_RM;
            grp        = 1'b1;
            fn         = sub_fn;
         end
         8'h68:        dst = DST_PUSH;
         default:      op_ok = 1'b0;
      endcase
   end

   assign mode_ok = ((mode_hi[7:6] == MODE_DIRECT) || (mode_hi[7:6] == MODE_INDIRECT))
                    && (!grp || sub_ok);
endmodule

// File: rtl/immop_alu.sv
module immop_alu
   import immop_pkg::*;
#(
   parameter int DW      = 32,
   parameter bit EXT_OVF = 1'b0
) (
   input  alu_fn_t         fn,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic [DW-1:0]   res,
   output logic            writes,
   output logic            sf,
   output logic            zf,
   output logic            of
);
   logic [DW-1:0] diff;
   assign diff = a - b;

   always_comb begin
      case (fn)
         FN_ADD:  res = a + b;
         FN_OR:   res = a | b;
         FN_AND:  res = a & b;
         FN_SUB:  res = diff;
         FN_XOR:  res = a ^ b;
         FN_CMP:  res = diff;
         default: res = b;
      endcase
   end

   assign writes = (fn != FN_CMP);

   // flag variant: sign-extended subtract, or sign-rule on the plain difference
   if (EXT_OVF) begin : g_ext
      logic [DW:0] wide;
      assign wide = {a[DW-1], a} - {b[DW-1], b};
      assign sf   = wide[DW-1];
      assign zf   = (wide[DW-1:0] == '0);
      assign of   = wide[DW] ^ wide[DW-1];
   end else begin : g_sign
      assign sf = diff[DW-1];
      assign zf = (diff == '0);
      assign of = (a[DW-1] ^ b[DW-1]) & (diff[DW-1] ^ a[DW-1]);
   end

   always_comb begin
      if (fn == FN_CMP) begin
         p_cmp_equal_r4: assert (zf == (a == b));
      end
   end
endmodule

// File: rtl/immop_regs.sv
module immop_regs
   import immop_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [REG_IDX_W-1:0] waddr,
   input  logic [DW-1:0]        wdata,
   input  logic [REG_IDX_W-1:0] raddr,
   output logic [DW-1:0]        rdata,
   input  logic [REG_IDX_W-1:0] vaddr,
   output logic [DW-1:0]        vdata
);
   logic [DW-1:0] words [REG_COUNT];

   for (genvar g = 0; g < REG_COUNT; g++) begin : g_word
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  q <= '0;
         else if (we && (waddr == REG_IDX_W'(g)))     q <= wdata;
      end
      assign words[g] = q;
   end

   assign rdata = words[raddr];
   assign vdata = words[vaddr];
endmodule

// File: rtl/immop_engine.sv
module immop_engine
   import immop_pkg::*;
#(
   parameter int DW      = 32,
   parameter int PC_W    = 16,
   parameter int SP_REG  = 4,
   parameter bit EXT_OVF = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [PC_W-1:0]      fetch_addr,
   input  logic [7:0]           fetch_byte,
   output logic [DW-1:0]        mem_addr,
   input  logic [DW-1:0]        mem_rdata,
   output logic                 mem_we,
   output logic [DW-1:0]        mem_wdata,
   input  logic [REG_IDX_W-1:0] view_sel,
   output logic [DW-1:0]        view_data,
   output logic                 flag_sf,
   output logic                 flag_zf,
   output logic                 flag_of,
   output logic                 done,
   output logic                 err
);
   localparam int              IMM_BYTES = DW / 8;
   localparam int              CNT_W     = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
   localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(IMM_BYTES - 1);
   localparam logic [DW-1:0]   SP_STEP   = DW'(IMM_BYTES);

   if ((DW % 8) != 0 || DW < 16) begin : g_bad_dw
      $error("immop_engine: DW must be a multiple of 8 and at least 16");
   end
   if (SP_REG < 0 || SP_REG >= REG_COUNT) begin : g_bad_sp
      $error("immop_engine: SP_REG out of range");
   end
   if (PC_W < 4) begin : g_bad_pc
      $error("immop_engine: PC_W too small");
   end

   state_t                 st_q;
   logic [PC_W-1:0]        pc_q;
   logic [7:0]             op_q, mode_q;
   logic [DW-1:0]          imm_q;
   logic [CNT_W-1:0]       cnt_q;

   logic [7:0]             op_view, mode_view;
   logic                   op_ok, needs_mode, mode_ok;
   alu_fn_t                fn;
   dst_t                   dst;
   logic                   exec, indirect, is_push;
   logic [REG_IDX_W-1:0]   src_idx;
   logic [DW-1:0]          src_val, operand, alu_res, sp_dec;
   logic                   alu_writes, c_sf, c_zf, c_of;
   logic                   reg_we, flags_we;
   logic [DW-1:0]          reg_wdata;

   // decode the byte in flight while it is being fetched, the stored one afterwards
   assign op_view   = (st_q == ST_OPCODE) ? fetch_byte : op_q;
   assign mode_view = (st_q == ST_MODE)   ? fetch_byte : mode_q;

   immop_decode u_dec (
      .opcode     (op_view),
      .mode_hi    (mode_view[7:3]),
      .op_ok      (op_ok),
      .needs_mode (needs_mode),
      .mode_ok    (mode_ok),
      .fn         (fn),
      .dst        (dst)
   );

   assign exec     = (st_q == ST_EXEC);
   assign is_push  = (dst == DST_PUSH);
   assign indirect = (dst == DST_RM) && (mode_q[7:6] == MODE_INDIRECT);

   always_comb begin
      case (dst)
         DST_ACC:   src_idx = '0;
         DST_RM:    src_idx = mode_q[2:0];
         DST_OPREG: src_idx = op_q[2:0];
         default:   src_idx = REG_IDX_W'(SP_REG);
      endcase
   end

   immop_regs #(.DW(DW)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .waddr (src_idx),
      .wdata (reg_wdata),
      .raddr (src_idx),
      .rdata (src_val),
      .vaddr (view_sel),
      .vdata (view_data)
   );

   assign operand = indirect ? mem_rdata : src_val;

   immop_alu #(.DW(DW), .EXT_OVF(EXT_OVF)) u_alu (
      .fn     (fn),
      .a      (operand),
      .b      (imm_q),
      .res    (alu_res),
      .writes (alu_writes),
      .sf     (c_sf),
      .zf     (c_zf),
      .of     (c_of)
   );

   assign sp_dec    = src_val - SP_STEP;
   assign reg_we    = exec && (is_push || (!indirect && alu_writes));
   assign reg_wdata = is_push ? sp_dec : alu_res;
   assign mem_we    = exec && (is_push || (indirect && alu_writes));
   assign mem_addr  = is_push ? sp_dec : src_val;
   assign mem_wdata = alu_res;
   assign flags_we  = exec && (fn == FN_CMP);
   assign fetch_addr = pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_OPCODE;
         pc_q   <= '0;
         op_q   <= '0;
         mode_q <= '0;
         imm_q  <= '0;
         cnt_q  <= '0;
         done   <= 1'b0;
         err    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            ST_OPCODE: begin
               if (!op_ok) begin
                  st_q <= ST_HALT;
                  err  <= 1'b1;
               end else begin
                  op_q  <= fetch_byte;
                  pc_q  <= pc_q + 1'b1;
                  cnt_q <= '0;
                  st_q  <= needs_mode ? ST_MODE : ST_IMM;
               end
            end
            ST_MODE: begin
               if (!mode_ok) begin
                  st_q <= ST_HALT;
                  err  <= 1'b1;
               end else begin
                  mode_q <= fetch_byte;
                  pc_q   <= pc_q + 1'b1;
                  st_q   <= ST_IMM;
               end
            end
            ST_IMM: begin
               imm_q <= {fetch_byte, imm_q[DW-1:8]};
               pc_q  <= pc_q + 1'b1;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_BYTE) st_q <= ST_EXEC;
            end
            ST_EXEC: begin
               done <= 1'b1;
               st_q <= ST_OPCODE;
            end
            default: st_q <= ST_HALT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_sf <= 1'b0;
         flag_zf <= 1'b0;
         flag_of <= 1'b0;
      end else if (flags_we) begin
         flag_sf <= c_sf;
         flag_zf <= c_zf;
         flag_of <= c_of;
      end
   end

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> ($stable(fetch_addr) && !done && !mem_we));
   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_mem_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> done);
   p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !flags_we |=> $stable({flag_sf, flag_zf, flag_of}));
   p_byte_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IMM) |=> (fetch_addr == $past(fetch_addr) + 1'b1));
endmodule

// File: tb/immop_engine_test.sv
`timescale 1ns/1ps
module immop_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] fetch_addr;
   logic [7:0]  fetch_byte;
   logic [31:0] mem_addr, mem_rdata, mem_wdata;
   logic        mem_we;
   logic [2:0]  view_sel = 3'd0;
   logic [31:0] view_data;
   logic        flag_sf, flag_zf, flag_of, done, err;

   logic [7:0]  rom  [256];
   logic [31:0] dmem [16];
   int checks = 0, fails = 0, wp = 0, cycles = 0;

   always #2.5 clk = ~clk;

   assign fetch_byte = rom[fetch_addr[7:0]];
   assign mem_rdata  = dmem[mem_addr[5:2]];
   always @(posedge clk) if (mem_we) dmem[mem_addr[5:2]] <= mem_wdata;

   immop_engine uut (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_byte(fetch_byte),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .view_sel(view_sel), .view_data(view_data),
      .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of), .done(done), .err(err)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; fails++;
         $display("FAIL watchdog expired: got %0d cycles expected < 150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
      end
   endtask

   task automatic clear();
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) rom[i] = 8'h00;
      wp = 0;
   endtask

   task automatic put8(input logic [7:0] b);
      rom[wp] = b;
      wp++;
   endtask

   task automatic put32(input logic [31:0] v);
      for (int k = 0; k < 4; k++) put8(v[8*k +: 8]);
   endtask

   task automatic mov(input int r, input logic [31:0] v);
      put8(8'hb8 | 8'(r));
      put32(v);
   endtask

   task automatic boot();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_done(output int gap);
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (!done && gap < 100);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R12 done timeout: got no pulse expected one within 100 cycles");
      end
   endtask

   task automatic run(input int n);
      int g;
      for (int i = 0; i < n; i++) wait_done(g);
   endtask

   task automatic peek(input int r, output logic [31:0] v);
      view_sel = 3'(r);
      #1;
      v = view_data;
   endtask

   function automatic logic [31:0] model(input int sub, input logic [31:0] a, input logic [31:0] b);
      case (sub)
         0: return a + b;
         1: return a | b;
         4: return a & b;
         5: return a - b;
         6: return a ^ b;
         default: return a;
      endcase
   endfunction

   function automatic logic [2:0] cmpflags(input logic [31:0] a, input logic [31:0] b);
      logic [31:0] d;
      d = a - b;
      return {d[31], d == 32'd0, (a[31] != b[31]) && (d[31] != a[31])};
   endfunction

   initial begin
      logic [31:0] v;
      int g;
      logic [7:0]  acc_op  [4];
      int          acc_sub [4];
      logic [31:0] av [6];
      logic [31:0] bv [6];
      int          subs [6];
      logic [31:0] ca [5];
      logic [31:0] cb [5];

      acc_op = '{8'h2d, 8'h25, 8'h0d, 8'h35};
      acc_sub = '{5, 4, 1, 6};
      av = '{32'h0d0c0baa, 32'h000000ff, 32'hd0c0b0a0, 32'hddccb0a0, 32'hffffffff, 32'h0};
      bv = '{32'h0d0c0b0a, 32'h0d0c0b0a, 32'h0d0c0b0a, 32'h0d0c0b0a, 32'h00000001, 32'h80000000};
      subs = '{0, 1, 4, 5, 6, 7};
      ca = '{32'h0d0c0b0a, 32'h0d0c0b07, 32'h0d0c0b0a, 32'h80000000, 32'h7fffffff};
      cb = '{32'h0d0c0b07, 32'h0d0c0b0a, 32'h0d0c0b0a, 32'h00000001, 32'hffffffff};
      for (int i = 0; i < 16; i++) dmem[i] = 32'h0;

      // R1: state set by a short program is cleared by reset
      clear();
      mov(0, 32'd5); put8(8'h3d); put32(32'd5);
      boot(); run(2);
      chk("R4", "zf before reset", 32'(flag_zf), 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "fetch_addr", 32'(fetch_addr), 32'd0);
      chk("R1", "done", 32'(done), 32'd0);
      chk("R1", "err", 32'(err), 32'd0);
      chk("R1", "flags", 32'({flag_sf, flag_zf, flag_of}), 32'd0);
      for (int r = 0; r < 8; r++) begin
         peek(r, v);
         chk("R1", $sformatf("reg%0d", r), v, 32'd0);
      end

      // R2 R11 R12: move to every register, then fall onto an undefined zero byte
      clear();
      for (int r = 0; r < 8; r++) mov(r, 32'h0d0c0b0a ^ (32'(r) * 32'h01010101));
      boot();
      wait_done(g);
      for (int r = 1; r < 8; r++) begin
         wait_done(g);
         chk("R12", "gap after 5-byte instruction", 32'(g), 32'd6);
      end
      chk("R11", "fetch_addr after eight moves", 32'(fetch_addr), 32'd40);
      chk("R10", "err before bad byte", 32'(err), 32'd0);
      for (int r = 0; r < 8; r++) begin
         peek(r, v);
         chk("R2", $sformatf("reg%0d", r), v, 32'h0d0c0b0a ^ (32'(r) * 32'h01010101));
      end
      repeat (4) @(negedge clk);
      chk("R10", "err on zero opcode", 32'(err), 32'd1);
      chk("R10", "fetch_addr frozen", 32'(fetch_addr), 32'd40);

      // R3 R9: accumulator forms after a compare that sets zf
      for (int o = 0; o < 4; o++) begin
         for (int i = 0; i < 6; i++) begin
            clear();
            mov(0, av[i]); put8(8'h3d); put32(av[i]); put8(acc_op[o]); put32(bv[i]);
            boot(); run(3);
            peek(0, v);
            chk("R3", $sformatf("op %02h case %0d", acc_op[o], i), v, model(acc_sub[o], av[i], bv[i]));
            chk("R9", "flags kept", 32'({flag_sf, flag_zf, flag_of}), 32'b010);
         end
      end

      // R4: accumulator compare
      for (int i = 0; i < 5; i++) begin
         clear();
         mov(0, ca[i]); put8(8'h3d); put32(cb[i]);
         boot(); run(2);
         chk("R4", $sformatf("flags case %0d", i), 32'({flag_sf, flag_zf, flag_of}), 32'(cmpflags(ca[i], cb[i])));
         peek(0, v);
         chk("R4", "reg0 unchanged", v, ca[i]);
      end

      // R5 R12: group form, direct register, all operations over all registers
      for (int s = 0; s < 6; s++) begin
         for (int r = 0; r < 8; r++) begin
            clear();
            mov(r, 32'hd0c0b0a0 + 32'(r));
            put8(8'h81); put8({2'b11, 3'(subs[s]), 3'(r)}); put32(32'h0d0c0b0a);
            boot(); wait_done(g); wait_done(g);
            chk("R12", "gap after 6-byte instruction", 32'(g), 32'd7);
            peek(r, v);
            chk("R5", $sformatf("sub %0d reg%0d", subs[s], r), v, model(subs[s], 32'hd0c0b0a0 + 32'(r), 32'h0d0c0b0a));
            if (subs[s] == 7)
               chk("R5", "compare flags", 32'({flag_sf, flag_zf, flag_of}),
                   32'(cmpflags(32'hd0c0b0a0 + 32'(r), 32'h0d0c0b0a)));
         end
      end

      // R6: group form, register-indirect through two base registers
      for (int s = 0; s < 6; s++) begin
         for (int b = 0; b < 2; b++) begin
            int rb;
            int wi;
            rb = (b == 0) ? 3 : 6;
            wi = (b == 0) ? 8 : 15;
            clear();
            dmem[wi] = 32'hd0c0b0a0;
            mov(rb, 32'(wi * 4));
            put8(8'h81); put8({2'b00, 3'(subs[s]), 3'(rb)}); put32(32'h0d0c0b0a);
            boot(); run(2);
            chk("R6", $sformatf("sub %0d word %0d", subs[s], wi), dmem[wi], model(subs[s], 32'hd0c0b0a0, 32'h0d0c0b0a));
            peek(rb, v);
            chk("R6", "base register unchanged", v, 32'(wi * 4));
            if (subs[s] == 7)
               chk("R6", "compare flags", 32'({flag_sf, flag_zf, flag_of}), 32'(cmpflags(32'hd0c0b0a0, 32'h0d0c0b0a)));
         end
      end

      // R7: move form with junk in the operation field
      clear();
      dmem[9] = 32'h0;
      mov(2, 32'h11111111);
      put8(8'hc7); put8({2'b11, 3'b101, 3'd2}); put32(32'h0d0c0b0a);
      mov(3, 32'h24);
      put8(8'hc7); put8({2'b00, 3'b111, 3'd3}); put32(32'hcafef00d);
      boot(); run(4);
      peek(2, v);
      chk("R7", "direct move", v, 32'h0d0c0b0a);
      chk("R7", "indirect move", dmem[9], 32'hcafef00d);
      peek(3, v);
      chk("R7", "base register unchanged", v, 32'h24);

      // R8: two pushes
      clear();
      dmem[4] = 32'h0; dmem[3] = 32'h0;
      mov(4, 32'h14);
      put8(8'h68); put32(32'h000000af);
      put8(8'h68); put32(32'h12345678);
      boot(); run(2);
      peek(4, v);
      chk("R8", "sp after first push", v, 32'h10);
      chk("R8", "first pushed word", dmem[4], 32'h000000af);
      run(1);
      peek(4, v);
      chk("R8", "sp after second push", v, 32'h0c);
      chk("R8", "second pushed word", dmem[3], 32'h12345678);
      chk("R9", "flags untouched by push", 32'({flag_sf, flag_zf, flag_of}), 32'd0);

      // R10: the error cases
      for (int e = 0; e < 5; e++) begin
         int dn;
         int exp_pc;
         int exp_dn;
         clear();
         exp_dn = 0;
         exp_pc = 1;
         case (e)
            0: begin put8(8'h05); exp_pc = 0; end
            1: begin put8(8'h81); put8({2'b11, 3'd2, 3'd0}); end
            2: begin put8(8'h81); put8({2'b11, 3'd3, 3'd1}); end
            3: begin put8(8'hc7); put8({2'b01, 3'd0, 3'd0}); end
            default: begin mov(1, 32'h5); put8(8'h06); exp_pc = 5; exp_dn = 1; end
         endcase
         boot();
         dn = 0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done) dn++;
         end
         chk("R10", $sformatf("err case %0d", e), 32'(err), 32'd1);
         chk("R10", $sformatf("fetch_addr case %0d", e), 32'(fetch_addr), 32'(exp_pc));
         chk("R10", $sformatf("done count case %0d", e), 32'(dn), 32'(exp_dn));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule